// File: doc/BRIEF.md
# Power-Down and Frame-Alignment Sequencer

This block sequences the frame timing of a sampling converter from power-down to valid output data. An active-low power-down input clears every register at once. After release, and once the release has passed through a reset synchroniser, the block starts a counter that tracks the master-clock position inside the current frame. It then waits a fixed number of whole frames before it raises a flag that lets the serial output carry data.

In master mode the frame counter starts as soon as the internal reset lifts. In slave mode the counter stays idle until the first rising edge of an external frame clock. That clock passes through a two-flop synchroniser and an edge detector. Slave mode also adds one frame to the settling wait. While running in slave mode, the block measures where each external frame-clock edge lands relative to the internal frame. If the offset is larger than a sixteenth of a frame, the block realigns the counter to that edge, emits a one-cycle resync pulse and restarts the settling wait.

The controller states are OFF (held in reset), AWAIT_EDGE (slave only, counter idle), SETTLE (counter running, counting frames) and VALID (output data enabled). The transitions are:
- OFF→SETTLE in master mode, and OFF→AWAIT_EDGE in slave mode, on the first clock after the internal reset lifts.
- AWAIT_EDGE→SETTLE on the first detected frame-clock rise.
- SETTLE→VALID when the last settling frame wraps.
- SETTLE→SETTLE or VALID→SETTLE on a resync.

Top module: `fsq_sequencer`

## Requirements
- R1: While `pd_n` is low, `run_en`, `data_valid` and `resync_pulse` are 0 and `frame_phase` is 0. A fall of `pd_n` clears them at once, without waiting for a clock edge, and they stay cleared whatever the other inputs do.
- R2: In master mode, counting from the first `clk` rising edge after `pd_n` rises, edges 1 and 2 leave `run_en` low and edge 3 raises it. From then on `frame_phase` advances by one every cycle, starting at 0.
- R3: The frame length is FRAME_SHORT cycles (default 256) when `long_frame` is 0 and FRAME_LONG cycles (default 384) when it is 1. `frame_phase` counts 0 to length-1 and then wraps to 0.
- R4: In master mode, `data_valid` rises at the clock edge that completes SETTLE_FRAMES (default 516) frames after `run_en` rose, that is at edge 3+SETTLE_FRAMES×length. At that edge `frame_phase` returns to 0.
- R5: In slave mode, `run_en` stays low and `frame_phase` stays 0 until a rising edge of `frame_clk_in` has been seen. A rise first sampled at clock edge k starts the counter at 0 at edge k+2. `data_valid` then rises at edge k+2+(SETTLE_FRAMES+1)×length.
- R6: In slave mode while running, each detected frame-clock rise is checked against the frame. The offset is the value the counter would take next, and the error is the smaller of offset and length−offset. If the error exceeds length/16, the counter is set to 0 at that edge and `resync_pulse` is high for the following cycle.
- R7: In slave mode, an edge whose error is at most length/16 causes no resync and leaves `data_valid` unchanged.
- R8: After a resync, `data_valid` is 0 and rises again (SETTLE_FRAMES+1)×length cycles after the resync edge.
- R9: In master mode, `frame_clk_in` has no effect: no resync occurs and `data_valid` stays high whatever its phase.
- R10: `resync_pulse` lasts exactly one cycle, and in that cycle `frame_phase` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| pd_n | input | 1 | Active-low power-down, asynchronous assert |
| master_mode | input | 1 | 1 = master timing, 0 = slave to `frame_clk_in` |
| long_frame | input | 1 | Frame length select: 0 = FRAME_SHORT, 1 = FRAME_LONG |
| frame_clk_in | input | 1 | External frame clock, asynchronous, used in slave mode |
| run_en | output | 1 | Internal frame timing is running |
| frame_phase | output | CNT_W | Master-clock position inside the frame |
| data_valid | output | 1 | Settling finished, serial data may be driven |
| resync_pulse | output | 1 | One-cycle pulse on a phase realignment |

## Verification
The following properties are checked on every clock:
- Outputs are cleared during power-down.
- The phase counter steps by one and stays below the frame length.
- The resync pulse is a single cycle and coincides with a zero phase.
- `data_valid` only rises on a frame boundary.
- Master mode never produces a resync.

Only the bench scenarios can show the absolute latencies from release and from the first frame-clock edge to valid data, the extra slave frame, and the exact window boundary of a sixteenth of a frame in both frame lengths. The same holds for the drift direction (early versus late edges) and for the recovery time after a resync.

// File: rtl/fsq_pkg.sv
`timescale 1ns/1ps
package fsq_pkg;

    typedef enum logic [1:0] {
        ST_OFF        = 2'd0,
        ST_AWAIT_EDGE = 2'd1,
        ST_SETTLE     = 2'd2,
        ST_VALID      = 2'd3
    } fsq_state_t;

endpackage

// File: rtl/fsq_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous-assert, synchronous-release reset chain.
module fsq_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) begin
                    chain_q[i] <= 1'b0;
                end else begin
                    if (i == 0) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/fsq_edge_sync.sv
`timescale 1ns/1ps
// Synchroniser for the external frame clock plus rising-edge detector.
module fsq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[STAGES-1:0], async_in};
    end

    assign rise = shift_q[STAGES-1] & ~shift_q[STAGES];
endmodule

// File: rtl/fsq_phase_ctr.sv
`timescale 1ns/1ps
// Frame-position counter with the drift judge for external edges.
module fsq_phase_ctr #(
    parameter int FRAME_SHORT = 256,
    parameter int FRAME_LONG  = 384,
    parameter int PHASE_DIV   = 16,
    parameter int CNT_W       = $clog2(FRAME_LONG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             long_frame,
    input  logic             run,
    input  logic             align,
    output logic [CNT_W-1:0] phase,
    output logic             wrap,
    output logic             drift_big
);
    localparam int LEN_W     = $clog2(FRAME_LONG + 1);
    localparam int WIN_SHORT = FRAME_SHORT / PHASE_DIV;
    localparam int WIN_LONG  = FRAME_LONG / PHASE_DIV;

    logic [LEN_W-1:0] len, last, cur, offset, err, win;
    logic             at_last;

    always_comb begin
        len     = long_frame ? LEN_W'(FRAME_LONG) : LEN_W'(FRAME_SHORT);
        win     = long_frame ? LEN_W'(WIN_LONG)   : LEN_W'(WIN_SHORT);
        last    = len - LEN_W'(1);
        cur     = LEN_W'(phase);
        at_last = (cur >= last);
        offset  = at_last ? '0 : cur + LEN_W'(1);
        err     = (offset > (len >> 1)) ? len - offset : offset;
    end

    assign wrap      = run & at_last;
    assign drift_big = (err > win);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              phase <= '0;
        else if (!run)           phase <= '0;
        else if (align || wrap)  phase <= '0;
        else                     phase <= phase + CNT_W'(1);
    end
endmodule

// File: rtl/fsq_settle_ctr.sv
`timescale 1ns/1ps
// Counts completed frames during the settling wait.
module fsq_settle_ctr #(
    parameter int SETTLE_FRAMES = 516
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    input  logic extra_frame,
    output logic done
);
    localparam int SC_W = $clog2(SETTLE_FRAMES + 2);

    logic [SC_W-1:0] count_q;
    logic [SC_W-1:0] target;

    assign target = extra_frame ? SC_W'(SETTLE_FRAMES + 1) : SC_W'(SETTLE_FRAMES);
    assign done   = tick && (count_q == target - SC_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             count_q <= '0;
        else if (clear || done) count_q <= '0;
        else if (tick)          count_q <= count_q + SC_W'(1);
    end
endmodule

// File: rtl/fsq_sequencer.sv
`timescale 1ns/1ps
module fsq_sequencer
    import fsq_pkg::*;
#(
    parameter int FRAME_SHORT   = 256,
    parameter int FRAME_LONG    = 384,
    parameter int SETTLE_FRAMES = 516,
    parameter int PHASE_DIV     = 16,
    parameter int SYNC_STAGES   = 2,
    parameter int RST_STAGES    = 2,
    localparam int CNT_W        = $clog2(FRAME_LONG)
) (
    input  logic             clk,
    input  logic             pd_n,
    input  logic             master_mode,
    input  logic             long_frame,
    input  logic             frame_clk_in,
    output logic             run_en,
    output logic [CNT_W-1:0] frame_phase,
    output logic             data_valid,
    output logic             resync_pulse
);
    fsq_state_t state_q, state_d;
    logic       srst_n;
    logic       fc_rise;
    logic       running;
    logic       wrap;
    logic       drift_big;
    logic       resync_now;
    logic       settle_done;
    logic       settle_clear;
    logic       resync_q;

    fsq_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
        .clk    (clk),
        .arst_n (pd_n),
        .srst_n (srst_n)
    );

    fsq_edge_sync #(.STAGES(SYNC_STAGES)) u_fc_sync (
        .clk      (clk),
        .rst_n    (srst_n),
        .async_in (frame_clk_in),
        .rise     (fc_rise)
    );

    fsq_phase_ctr #(
        .FRAME_SHORT (FRAME_SHORT),
        .FRAME_LONG  (FRAME_LONG),
        .PHASE_DIV   (PHASE_DIV),
        .CNT_W       (CNT_W)
    ) u_phase (
        .clk        (clk),
        .rst_n      (srst_n),
        .long_frame (long_frame),
        .run        (running),
        .align      (resync_now),
        .phase      (frame_phase),
        .wrap       (wrap),
        .drift_big  (drift_big)
    );

    fsq_settle_ctr #(.SETTLE_FRAMES(SETTLE_FRAMES)) u_settle (
        .clk         (clk),
        .rst_n       (srst_n),
        .clear       (settle_clear),
        .tick        (wrap),
        .extra_frame (~master_mode),
        .done        (settle_done)
    );

    assign running      = (state_q == ST_SETTLE) || (state_q == ST_VALID);
    assign resync_now   = running && !master_mode && fc_rise && drift_big;
    assign settle_clear = (state_q != ST_SETTLE) || resync_now;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                state_d = master_mode ? ST_SETTLE : ST_AWAIT_EDGE;
            end
            ST_AWAIT_EDGE: begin
                if (fc_rise) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (resync_now)       state_d = ST_SETTLE;
                else if (settle_done) state_d = ST_VALID;
            end
            ST_VALID: begin
                if (resync_now) state_d = ST_SETTLE;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n) state_q <= ST_OFF;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n) resync_q <= 1'b0;
        else         resync_q <= resync_now;
    end

    // Output decode
    always_comb begin
        run_en       = 1'b0;
        data_valid   = 1'b0;
        resync_pulse = resync_q;
        unique case (state_q)
            ST_OFF:        begin run_en = 1'b0; data_valid = 1'b0; end
            ST_AWAIT_EDGE: begin run_en = 1'b0; data_valid = 1'b0; end
            ST_SETTLE:     begin run_en = 1'b1; data_valid = 1'b0; end
            ST_VALID:      begin run_en = 1'b1; data_valid = 1'b1; end
            default:       begin run_en = 1'b0; data_valid = 1'b0; end
        endcase
    end
endmodule

// File: rtl/fsq_sequencer_chk.sv
`timescale 1ns/1ps
module fsq_sequencer_chk #(
    parameter int FRAME_SHORT = 256,
    parameter int FRAME_LONG  = 384,
    parameter int CNT_W       = $clog2(FRAME_LONG)
) (
    input logic             clk,
    input logic             pd_n,
    input logic             master_mode,
    input logic             long_frame,
    input logic             run_en,
    input logic [CNT_W-1:0] frame_phase,
    input logic             data_valid,
    input logic             resync_pulse
);
    AST_PD_CLEAR: assert property (@(posedge clk)
        !pd_n |-> (!run_en && !data_valid && !resync_pulse && frame_phase == '0)); // R1

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!pd_n)
        (run_en && $past(run_en) && !resync_pulse && frame_phase != '0)
        |-> frame_phase == $past(frame_phase) + CNT_W'(1)); // R2

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!pd_n)
        run_en |-> (long_frame ? (frame_phase <= CNT_W'(FRAME_LONG - 1))
                               : (frame_phase <= CNT_W'(FRAME_SHORT - 1)))); // R3

    AST_VALID_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!pd_n)
        $rose(data_valid) |-> frame_phase == '0); // R4

    AST_IDLE_PHASE: assert property (@(posedge clk) disable iff (!pd_n)
        !run_en |-> (frame_phase == '0 && !data_valid)); // R5

    AST_RESYNC_DROPS_VALID: assert property (@(posedge clk) disable iff (!pd_n)
        resync_pulse |-> !data_valid); // R8

    AST_MASTER_QUIET: assert property (@(posedge clk) disable iff (!pd_n)
        (master_mode && $past(master_mode)) |-> !resync_pulse); // R9

    AST_RESYNC_SINGLE: assert property (@(posedge clk) disable iff (!pd_n)
        resync_pulse |=> !resync_pulse); // R10

    AST_RESYNC_ZERO: assert property (@(posedge clk) disable iff (!pd_n)
        resync_pulse |-> frame_phase == '0); // R10
endmodule

bind fsq_sequencer fsq_sequencer_chk #(
    .FRAME_SHORT (FRAME_SHORT),
    .FRAME_LONG  (FRAME_LONG),
    .CNT_W       (CNT_W)
) u_chk (
    .clk          (clk),
    .pd_n         (pd_n),
    .master_mode  (master_mode),
    .long_frame   (long_frame),
    .run_en       (run_en),
    .frame_phase  (frame_phase),
    .data_valid   (data_valid),
    .resync_pulse (resync_pulse)
);

// File: tb/test_fsq_sequencer.sv
`timescale 1ns/1ps
module test_fsq_sequencer;
    localparam int FS    = 32;
    localparam int FL    = 48;
    localparam int SET   = 3;
    localparam int CNT_W = $clog2(FL);

    typedef struct packed {
        logic   master;
        logic   long_fr;
        logic   [7:0] drift;   // signed shift of the external frame clock
        logic   exp_resync;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0,  8'sd5, 1'b0},
        '{1'b1, 1'b1, -8'sd7, 1'b0},
        '{1'b0, 1'b0,  8'sd2, 1'b0},
        '{1'b0, 1'b0,  8'sd3, 1'b1},
        '{1'b0, 1'b0, -8'sd3, 1'b1},
        '{1'b0, 1'b1,  8'sd3, 1'b0},
        '{1'b0, 1'b1, -8'sd4, 1'b1},
        '{1'b0, 1'b1, -8'sd3, 1'b0}
    };

    logic clk = 1'b0;
    logic pd_n = 1'b0;
    logic master_mode = 1'b1;
    logic long_frame = 1'b0;
    logic frame_clk = 1'b0;
    logic run_en, data_valid, resync_pulse;
    logic [CNT_W-1:0] frame_phase;

    int checks = 0;
    int errors = 0;

    // frame clock model
    logic fc_en = 1'b0;
    int   flen = FS;
    int   fc_pos = 0;
    int   adj_val = 0;
    logic adj_tog = 1'b0;
    logic adj_seen = 1'b0;

    always #2.5 clk = ~clk;

    fsq_sequencer #(
        .FRAME_SHORT   (FS),
        .FRAME_LONG    (FL),
        .SETTLE_FRAMES (SET),
        .PHASE_DIV     (16)
    ) i_fsq_sequencer (
        .clk          (clk),
        .pd_n         (pd_n),
        .master_mode  (master_mode),
        .long_frame   (long_frame),
        .frame_clk_in (frame_clk),
        .run_en       (run_en),
        .frame_phase  (frame_phase),
        .data_valid   (data_valid),
        .resync_pulse (resync_pulse)
    );

    always @(negedge clk) begin
        if (!fc_en) begin
            fc_pos    <= 0;
            frame_clk <= 1'b0;
        end else begin
            frame_clk <= (fc_pos < flen / 2);
            if (adj_tog != adj_seen) begin
                adj_seen <= adj_tog;
                fc_pos   <= (fc_pos + 1 + flen + adj_val) % flen;
            end else begin
                fc_pos <= (fc_pos + 1) % flen;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        #(150000 * 5);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, m, nrs, bad, recov, fl, exp_lat;
        for (int v = 0; v < NV; v++) begin
            fl = VEC[v].long_fr ? FL : FS;
            @(posedge clk); #1;
            pd_n = 1'b0; fc_en = 1'b0;
            master_mode = VEC[v].master; long_frame = VEC[v].long_fr; flen = fl;
            repeat (3) @(posedge clk);
            @(negedge clk);
            chk(!run_en && !data_valid && !resync_pulse && frame_phase == '0,
                "R1 outputs cleared in power-down", int'(run_en) + int'(data_valid), 0);
            @(posedge clk); #1;
            pd_n = 1'b1;
            n = 0;
            if (VEC[v].master) begin
                fc_en = 1'b1;
                while (n < 20000) begin
                    @(posedge clk); n++;
                    @(negedge clk);
                    if (n == 2) chk(!run_en, "R2 run_en low at edge 2", int'(run_en), 0);
                    if (n == 3) chk(run_en && frame_phase == '0, "R2 run_en high at edge 3",
                                    int'(run_en), 1);
                    if (n == 4) chk(frame_phase == 1, "R2 phase steps", int'(frame_phase), 1);
                    if (data_valid) break;
                end
                exp_lat = 3 + SET * fl;
                chk(n == exp_lat, "R4 master settle latency", n, exp_lat);
                m = 0;
                do begin
                    @(negedge clk); m++;
                end while (frame_phase != '0 && m < 1000);
                chk(m == fl, "R3 frame length", m, fl);
            end else begin
                repeat (6) @(negedge clk);
                chk(!run_en && frame_phase == '0, "R5 idle until frame clock edge",
                    int'(run_en), 0);
                @(posedge clk); #1;
                fc_en = 1'b1;
                while (n < 20000) begin
                    @(posedge clk); n++;
                    @(negedge clk);
                    if (data_valid) break;
                end
                exp_lat = 3 + (SET + 1) * fl;
                chk(n == exp_lat, "R5 slave settle latency", n, exp_lat);
            end
            // shift the external frame clock
            m = 0;
            do begin
                @(negedge clk); m++;
            end while (fc_pos != (3 * fl) / 4 && m < 1000);
            @(posedge clk); #1;
            adj_val = int'($signed(VEC[v].drift));
            adj_tog = ~adj_tog;
            nrs = 0; bad = 0; recov = -1;
            for (int i = 0; i < 3 * fl; i++) begin
                @(negedge clk);
                if (resync_pulse) begin
                    nrs++;
                    chk(frame_phase == '0 && !data_valid, "R10 phase zero on resync pulse",
                        int'(frame_phase), 0);
                    m = 0;
                    while (!data_valid && m < 20000) begin
                        @(posedge clk); m++;
                        @(negedge clk);
                        if (m == 1) chk(!resync_pulse, "R10 pulse one cycle",
                                        int'(resync_pulse), 0);
                        if (resync_pulse) nrs++;
                    end
                    recov = m;
                end else if (!data_valid) begin
                    bad++;
                end
            end
            if (VEC[v].master)
                chk(nrs == 0 && bad == 0, "R9 master ignores frame clock", nrs, 0);
            else if (VEC[v].exp_resync) begin
                chk(nrs == 1, "R6 resync on large drift", nrs, 1);
                chk(recov == (SET + 1) * fl, "R8 valid recovery after resync",
                    recov, (SET + 1) * fl);
            end else begin
                chk(nrs == 0, "R7 no resync inside window", nrs, 0);
                chk(bad == 0, "R7 data_valid held", bad, 0);
            end
        end

        // directed: asynchronous power-down while valid
        @(negedge clk);
        chk(data_valid, "R1 precondition valid", int'(data_valid), 1);
        @(posedge clk); #1;
        pd_n = 1'b0;
        #0.5;
        chk(!run_en && !data_valid && frame_phase == '0, "R1 asynchronous clear",
            int'(run_en) + int'(data_valid), 0);
        // directed: stay cleared while frame clock keeps running
        bad = 0;
        for (int i = 0; i < 2 * FL; i++) begin
            @(negedge clk);
            if (run_en || data_valid || resync_pulse) bad++;
        end
        chk(bad == 0, "R1 held during power-down", bad, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule